// File: doc/BRIEF.md
# Cascadable Correlator Score Combiner

This block turns eight per-stage correlation counts into one 13-bit score and forwards it down a chain of devices. Each stage count is weighted in one of two ways. In narrow mode, for 1-bit data, every stage counts once. In wide mode, for 8-bit data, stage k is weighted by 2^k. The weighted counts are summed and a loadable offset is added. The result then passes through an alignment pipeline whose length can be set from 1 to 16 clocks. After the pipeline, the undelayed score arriving from the upstream device is added to form the cascade output.

Several devices can be chained. Each cascade output feeds the cascade input of the next device, and the first device in the chain receives zero. The alignment delay of each device is chosen so that all partial scores of the same sample meet in the chain.

A small control port loads the configuration. It has a 3-bit address, an 8-bit data bus and an active-low load strobe, and a write commits when the strobe returns high. A dual configuration stores a second offset and forces the shortest delay.

Top module: `cascade_score_combiner`

## Requirements
- R1: After reset every control register is zero, the delay line is empty and the weighting is narrow, so with all stage counts at zero `cas_out_o` equals `cas_in_i`.
- R2: With `wide_mode_i` low, the score entering the delay is the plain sum of the eight 6-bit stage counts plus the active offset.
- R3: With `wide_mode_i` high, stage k (bits 6k+5..6k of `stage_cnt_i`) is shifted left by k before summing, so stage 7 carries the largest weight.
- R4: Address 2 loads offset A bits 12..8 from data bits 4..0, and data bits 7..5 are dropped. Address 3 loads offset A bits 7..0.
- R5: Address 4 loads a 4-bit delay code from data bits 3..0, and code c delays the score by c+1 clocks. A new code selects a different tap from the next clock on, and the pipeline contents are kept.
- R6: `cas_out_o` is the delayed score plus the current, undelayed `cas_in_i`, and every sum wraps modulo 8192.
- R7: A write uses the address and data present at the first clock edge where the strobe is seen high after being low. Registers change only after that edge, and data changes while the strobe is low have no effect.
- R8: Writes to address 0 and address 7 leave every register, and so the output, unchanged.
- R9: Address 1 sets dual mode (bit 0) and offset-B select (bit 1). In dual mode the delay is always 1 clock whatever the delay code, and offset B is added when the select bit is set.
- R10: Addresses 5 and 6 load offset B with the same field layout as offset A. Outside dual mode, offset B and the select bit have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stage_cnt_i | input | 48 | Eight 6-bit stage counts, stage k in bits 6k+5..6k |
| wide_mode_i | input | 1 | 1 = binary stage weighting (8-bit data), 0 = unit weighting |
| cas_in_i | input | 13 | Partial score from the upstream device |
| cfg_addr_i | input | 3 | Control register address |
| cfg_data_i | input | 8 | Control write data |
| cfg_load_n_i | input | 1 | Active-low load strobe; commits on its rising edge |
| cas_out_o | output | 13 | Combined cascade score |

## Verification
The hardest case to reach from the ports is a change of the delay code while the pipeline holds a run of different scores. It shows that the tap switches at once and that nothing is flushed. The stimulus keeps a stream of random stage counts running while it writes codes 5, 0 and 15 one after another. It then writes a long code while dual mode is active, where the code must be ignored. Wraparound is reached by pairing full wide-mode counts with the largest offset and a large cascade input.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int CCS_STAGES    = 8;
  localparam int CCS_CNT_W     = 6;
  localparam int CCS_SCORE_W   = 13;
  localparam int CCS_DLY_DEPTH = 16;
  localparam int CCS_DATA_W    = 8;
  localparam int CCS_ADDR_W    = 3;

  // control port address decode; addresses are fixed by the chain software
  typedef enum logic [2:0] {
    ADR_MASK    = 3'd0,
    ADR_CFG     = 3'd1,
    ADR_OFSA_HI = 3'd2,
    ADR_OFSA_LO = 3'd3,
    ADR_DLY     = 3'd4,
    ADR_OFSB_HI = 3'd5,
    ADR_OFSB_LO = 3'd6,
    ADR_RSVD    = 3'd7
  } ccs_addr_e;

  localparam int CFG_DUAL_BIT = 0;
  localparam int CFG_SELB_BIT = 1;

endpackage

// File: rtl/ccs_ctrl_regs.sv
module ccs_ctrl_regs
  import ccs_pkg::*;
#(
  parameter int SCORE_W = CCS_SCORE_W,
  parameter int DATA_W  = CCS_DATA_W,
  parameter int ADDR_W  = CCS_ADDR_W,
  parameter int TAP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               load_n_i,
  output logic               wr_stb_o,
  output logic [SCORE_W-1:0] ofs_a_o,
  output logic [SCORE_W-1:0] ofs_b_o,
  output logic [TAP_W-1:0]   dly_code_o,
  output logic               dual_o,
  output logic               sel_b_o
);

  localparam int LO_W = DATA_W;
  localparam int HI_W = SCORE_W - DATA_W;

  logic               load_n_q;
  logic [SCORE_W-1:0] ofs_a_q, ofs_a_nxt;
  logic [SCORE_W-1:0] ofs_b_q, ofs_b_nxt;
  logic [TAP_W-1:0]   dly_q, dly_nxt;
  logic               dual_q, dual_nxt;
  logic               selb_q, selb_nxt;
  logic               wr_stb;

  // strobe low in the previous cycle and high now: commit
  assign wr_stb = ~load_n_q & load_n_i;

  always_comb begin
    ofs_a_nxt = ofs_a_q;
    ofs_b_nxt = ofs_b_q;
    dly_nxt   = dly_q;
    dual_nxt  = dual_q;
    selb_nxt  = selb_q;
    if (wr_stb) begin
      case (addr_i)
        ADR_CFG: begin
          dual_nxt = data_i[CFG_DUAL_BIT];
          selb_nxt = data_i[CFG_SELB_BIT];
        end
        ADR_OFSA_HI: ofs_a_nxt = {data_i[HI_W-1:0], ofs_a_q[LO_W-1:0]};
        ADR_OFSA_LO: ofs_a_nxt = {ofs_a_q[SCORE_W-1:LO_W], data_i};
        ADR_DLY:     dly_nxt   = data_i[TAP_W-1:0];
        ADR_OFSB_HI: ofs_b_nxt = {data_i[HI_W-1:0], ofs_b_q[LO_W-1:0]};
        ADR_OFSB_LO: ofs_b_nxt = {ofs_b_q[SCORE_W-1:LO_W], data_i};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_n_q <= 1'b1;
      ofs_a_q  <= '0;
      ofs_b_q  <= '0;
      dly_q    <= '0;
      dual_q   <= 1'b0;
      selb_q   <= 1'b0;
    end else begin
      load_n_q <= load_n_i;
      if (wr_stb) begin
        ofs_a_q <= ofs_a_nxt;
        ofs_b_q <= ofs_b_nxt;
        dly_q   <= dly_nxt;
        dual_q  <= dual_nxt;
        selb_q  <= selb_nxt;
      end
    end
  end

  assign wr_stb_o   = wr_stb;
  assign ofs_a_o    = ofs_a_q;
  assign ofs_b_o    = ofs_b_q;
  assign dly_code_o = dly_q;
  assign dual_o     = dual_q;
  assign sel_b_o    = selb_q;

endmodule

// File: rtl/ccs_weight_sum.sv
module ccs_weight_sum
  import ccs_pkg::*;
#(
  parameter int STAGES  = CCS_STAGES,
  parameter int CNT_W   = CCS_CNT_W,
  parameter int SCORE_W = CCS_SCORE_W
) (
  input  logic [STAGES*CNT_W-1:0] cnt_i,
  input  logic                    wide_i,
  input  logic [SCORE_W-1:0]      ofs_i,
  output logic [SCORE_W-1:0]      score_o
);

  logic [SCORE_W-1:0] wt [STAGES];

  // one weighting lane per stage; the shift amount is the stage index
  for (genvar g = 0; g < STAGES; g++) begin : g_lane
    logic [SCORE_W-1:0] ext;
    assign ext   = SCORE_W'(cnt_i[g*CNT_W +: CNT_W]);
    assign wt[g] = wide_i ? (ext << g) : ext;
  end

  always_comb begin
    logic [SCORE_W-1:0] acc;
    acc = ofs_i;
    for (int k = 0; k < STAGES; k++) begin
      acc = acc + wt[k];
    end
    score_o = acc;
  end

endmodule

// File: rtl/ccs_align_delay.sv
module ccs_align_delay
  import ccs_pkg::*;
#(
  parameter int WIDTH = CCS_SCORE_W,
  parameter int DEPTH = CCS_DLY_DEPTH,
  localparam int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [WIDTH-1:0] sr_q   [DEPTH];
  logic [WIDTH-1:0] sr_nxt [DEPTH];

  always_comb begin
    sr_nxt[0] = din_i;
    for (int i = 1; i < DEPTH; i++) begin
      sr_nxt[i] = sr_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_nxt[i];
    end
  end

  // tap 0 holds the score registered at the latest edge: one clock of delay
  assign dout_o = sr_q[tap_i];

endmodule

// File: rtl/cascade_score_combiner.sv
module cascade_score_combiner
  import ccs_pkg::*;
#(
  parameter int STAGES    = CCS_STAGES,
  parameter int CNT_W     = CCS_CNT_W,
  parameter int SCORE_W   = CCS_SCORE_W,
  parameter int DLY_DEPTH = CCS_DLY_DEPTH,
  parameter int DATA_W    = CCS_DATA_W,
  parameter int ADDR_W    = CCS_ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [STAGES*CNT_W-1:0] stage_cnt_i,
  input  logic                    wide_mode_i,
  input  logic [SCORE_W-1:0]      cas_in_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [DATA_W-1:0]       cfg_data_i,
  input  logic                    cfg_load_n_i,
  output logic [SCORE_W-1:0]      cas_out_o
);

  localparam int TAP_W = $clog2(DLY_DEPTH);

  logic [1:0]         rst_pipe;
  logic               rst_n_int;
  logic               wr_stb;
  logic [SCORE_W-1:0] ofs_a, ofs_b, ofs_sel;
  logic [TAP_W-1:0]   dly_code, tap_sel;
  logic               dual_en, sel_b;
  logic [SCORE_W-1:0] score_d, score_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  ccs_ctrl_regs #(
    .SCORE_W (SCORE_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .TAP_W   (TAP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .addr_i     (cfg_addr_i),
    .data_i     (cfg_data_i),
    .load_n_i   (cfg_load_n_i),
    .wr_stb_o   (wr_stb),
    .ofs_a_o    (ofs_a),
    .ofs_b_o    (ofs_b),
    .dly_code_o (dly_code),
    .dual_o     (dual_en),
    .sel_b_o    (sel_b)
  );

  assign ofs_sel = (dual_en && sel_b) ? ofs_b : ofs_a;
  assign tap_sel = dual_en ? '0 : dly_code;

  ccs_weight_sum #(
    .STAGES  (STAGES),
    .CNT_W   (CNT_W),
    .SCORE_W (SCORE_W)
  ) u_wsum (
    .cnt_i   (stage_cnt_i),
    .wide_i  (wide_mode_i),
    .ofs_i   (ofs_sel),
    .score_o (score_d)
  );

  ccs_align_delay #(
    .WIDTH (SCORE_W),
    .DEPTH (DLY_DEPTH)
  ) u_dly (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .din_i  (score_d),
    .tap_i  (tap_sel),
    .dout_o (score_q)
  );

  // chain adder: upstream partial score is not delayed
  assign cas_out_o = score_q + cas_in_i;

endmodule

module ccs_checker #(
  parameter int SCORE_W = 13,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int TAP_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_stb,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  data,
  input logic [SCORE_W-1:0] ofs_a,
  input logic [SCORE_W-1:0] ofs_b,
  input logic [TAP_W-1:0]   dly_code,
  input logic               dual_en,
  input logic               sel_b,
  input logic [SCORE_W-1:0] score_d,
  input logic [SCORE_W-1:0] cas_in,
  input logic [SCORE_W-1:0] cas_out
);

  localparam int HI_W = SCORE_W - DATA_W;

  // R4
  offa_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd2) |=> ofs_a[SCORE_W-1:DATA_W] == $past(data[HI_W-1:0]));

  // R10
  offb_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd6) |=> ofs_b[DATA_W-1:0] == $past(data));

  // R5
  dly_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd4) |=> dly_code == $past(data[TAP_W-1:0]));

  // R8
  ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (addr == 3'd0 || addr == 3'd7)) |=>
      $stable({ofs_a, ofs_b, dly_code, dual_en, sel_b}));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({ofs_a, ofs_b, dly_code, dual_en, sel_b}));

  // R9
  dual_min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_en && $past(dual_en)) |-> cas_out == SCORE_W'($past(score_d) + cas_in));

endmodule

bind cascade_score_combiner ccs_checker #(
  .SCORE_W (SCORE_W),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .TAP_W   (TAP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .wr_stb   (wr_stb),
  .addr     (cfg_addr_i),
  .data     (cfg_data_i),
  .ofs_a    (ofs_a),
  .ofs_b    (ofs_b),
  .dly_code (dly_code),
  .dual_en  (dual_en),
  .sel_b    (sel_b),
  .score_d  (score_d),
  .cas_in   (cas_in_i),
  .cas_out  (cas_out_o)
);

// File: tb/tb_cascade_score_combiner.sv
`timescale 1ns/1ps
module tb_cascade_score_combiner;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] stage_cnt;
  logic        wide_mode;
  logic [12:0] cas_in;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic        cfg_load_n;
  logic [12:0] cas_out;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    cmp_en   = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  always #5 clk = ~clk;

  cascade_score_combiner dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stage_cnt_i  (stage_cnt),
    .wide_mode_i  (wide_mode),
    .cas_in_i     (cas_in),
    .cfg_addr_i   (cfg_addr),
    .cfg_data_i   (cfg_data),
    .cfg_load_n_i (cfg_load_n),
    .cas_out_o    (cas_out)
  );

  // ---------------- behavioural reference ----------------
  int   m_ofs_a, m_ofs_b, m_dly;
  bit   m_dual, m_selb, m_prev_ld;
  int   hist[$];

  function automatic int model_score();
    int s;
    int ofs;
    s = 0;
    for (int k = 0; k < 8; k++) begin
      int c;
      c = int'(stage_cnt[k*6 +: 6]);
      s += wide_mode ? (c * (1 << k)) : c;
    end
    ofs = (m_dual && m_selb) ? m_ofs_b : m_ofs_a;
    return (s + ofs) % 8192;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ofs_a = 0; m_ofs_b = 0; m_dly = 0; m_dual = 0; m_selb = 0;
      m_prev_ld = 1;
      hist.delete();
      for (int i = 0; i < 16; i++) hist.push_back(0);
    end else begin
      hist.push_front(model_score());
      void'(hist.pop_back());
      if (!m_prev_ld && cfg_load_n) begin
        case (cfg_addr)
          3'd1: begin m_dual = cfg_data[0]; m_selb = cfg_data[1]; end
          3'd2: m_ofs_a = (int'(cfg_data[4:0]) << 8) | (m_ofs_a & 8'hFF);
          3'd3: m_ofs_a = (m_ofs_a & 13'h1F00) | int'(cfg_data);
          3'd4: m_dly = int'(cfg_data[3:0]);
          3'd5: m_ofs_b = (int'(cfg_data[4:0]) << 8) | (m_ofs_b & 8'hFF);
          3'd6: m_ofs_b = (m_ofs_b & 13'h1F00) | int'(cfg_data);
          default: ;
        endcase
      end
      m_prev_ld = cfg_load_n;
    end
  end

  function automatic int model_out();
    int tap;
    tap = m_dual ? 0 : m_dly;
    return (hist[tap] + int'(cas_in)) % 8192;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (cmp_en && !done) chk(int'(cas_out) == model_out(), cur_req, int'(cas_out), model_out());
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_counts(input int c0, input int c1, input int c2, input int c3,
                            input int c4, input int c5, input int c6, input int c7);
    stage_cnt = {6'(c7), 6'(c6), 6'(c5), 6'(c4), 6'(c3), 6'(c2), 6'(c1), 6'(c0)};
  endtask

  task automatic rand_counts();
    for (int k = 0; k < 8; k++) stage_cnt[k*6 +: 6] = 6'($urandom_range(0, 32));
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_data = d; cfg_load_n = 1'b0;
    repeat (2) @(negedge clk);
    cfg_load_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_random(input int n, input bit rand_cas);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rand_counts();
      if (rand_cas) cas_in = 13'($urandom_range(0, 8191));
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; stage_cnt = '0; wide_mode = 1'b0; cas_in = '0;
    cfg_addr = '0; cfg_data = '0; cfg_load_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    // R1: reset state passes the cascade input straight through
    cur_req = "R1";
    cas_in = 13'h155;
    @(posedge clk); #3;
    chk(cas_out == 13'h155, "R1", int'(cas_out), 'h155);

    // R2: unit weighting
    cur_req = "R2";
    @(negedge clk); cas_in = '0; set_counts(1, 2, 3, 4, 5, 6, 7, 8);
    @(posedge clk); #3;
    chk(cas_out == 13'd36, "R2", int'(cas_out), 36);
    run_random(20, 0);

    // R3: binary weighting, full counts give 32*255
    cur_req = "R3";
    @(negedge clk); wide_mode = 1'b1; set_counts(32, 32, 32, 32, 32, 32, 32, 32);
    @(posedge clk); #3;
    chk(cas_out == 13'd8160, "R3", int'(cas_out), 8160);
    @(negedge clk); set_counts(0, 0, 0, 0, 0, 0, 0, 1);
    @(posedge clk); #3;
    chk(cas_out == 13'd128, "R3", int'(cas_out), 128);
    run_random(20, 0);

    // R4: offset A fields; upper data bits beyond the field are dropped
    cur_req = "R4";
    @(negedge clk); set_counts(0, 0, 0, 0, 0, 0, 0, 0);
    cfg_write(3'd2, 8'hE3);
    cfg_write(3'd3, 8'hAB);
    @(posedge clk); #3;
    chk(cas_out == 13'h3AB, "R4", int'(cas_out), 'h3AB);
    run_random(15, 0);

    // R6: cascade input added undelayed, wrap modulo 8192
    cur_req = "R6";
    cfg_write(3'd2, 8'h1F);
    cfg_write(3'd3, 8'hFF);
    @(negedge clk); set_counts(32, 32, 32, 32, 32, 32, 32, 32); cas_in = 13'h1000;
    @(posedge clk); #3;
    chk(cas_out == 13'((8160 + 8191 + 4096) % 8192), "R6", int'(cas_out),
        (8160 + 8191 + 4096) % 8192);
    run_random(20, 1);

    // R5: delay codes changed while the pipeline is full of distinct scores
    cur_req = "R5";
    @(negedge clk); cas_in = '0;
    cfg_write(3'd4, 8'hF5);
    run_random(20, 0);
    cfg_write(3'd4, 8'h00);
    run_random(5, 0);
    cfg_write(3'd4, 8'h0F);
    run_random(20, 1);
    // single marker through a 16-clock pipeline
    @(negedge clk); cas_in = '0; wide_mode = 1'b0;
    cfg_write(3'd2, 8'h00); cfg_write(3'd3, 8'h00);
    set_counts(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (17) @(negedge clk);
    set_counts(9, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); set_counts(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (14) @(posedge clk);
    #3 chk(cas_out == 13'd0, "R5", int'(cas_out), 0);
    @(posedge clk); #3;
    chk(cas_out == 13'd9, "R5", int'(cas_out), 9);

    // R7: data moving while the strobe is low; commit only after the rise
    cur_req = "R7";
    cfg_write(3'd4, 8'h00);
    @(negedge clk); cfg_addr = 3'd3; cfg_data = 8'h11; cfg_load_n = 1'b0;
    @(negedge clk); cfg_data = 8'h22;
    @(posedge clk); #3;
    chk(cas_out == 13'd0, "R7", int'(cas_out), 0);
    @(negedge clk); cfg_data = 8'h5C; cfg_load_n = 1'b1;
    @(posedge clk); #3;
    chk(cas_out == 13'd0, "R7", int'(cas_out), 0);
    @(posedge clk); #3;
    chk(cas_out == 13'h5C, "R7", int'(cas_out), 'h5C);

    // R8: ignored addresses
    cur_req = "R8";
    cfg_write(3'd0, 8'hFF);
    cfg_write(3'd7, 8'hFF);
    @(posedge clk); #3;
    chk(cas_out == 13'h5C, "R8", int'(cas_out), 'h5C);
    run_random(10, 1);

    // R10: offset B and select bit inert outside dual mode
    cur_req = "R10";
    @(negedge clk); cas_in = '0; set_counts(0, 0, 0, 0, 0, 0, 0, 0);
    cfg_write(3'd5, 8'h07);
    cfg_write(3'd6, 8'h70);
    cfg_write(3'd1, 8'h02);
    @(posedge clk); #3;
    chk(cas_out == 13'h5C, "R10", int'(cas_out), 'h5C);
    run_random(10, 0);

    // R9: dual mode forces one clock of delay and uses offset B when selected
    cur_req = "R9";
    cfg_write(3'd4, 8'h0C);
    cfg_write(3'd1, 8'h01);
    run_random(15, 1);
    cfg_write(3'd1, 8'h03);
    @(negedge clk); cas_in = '0; set_counts(0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #3;
    chk(cas_out == 13'h770, "R9", int'(cas_out), 'h770);
    run_random(20, 1);
    cfg_write(3'd1, 8'h00);
    run_random(20, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule